// File: doc/BRIEF.md
# SOC Threshold Alert Monitor

This block watches an 8-bit state-of-charge reading, in steps of 1%, and compares it with an upper and a lower limit. Both limits sit in one 16-bit threshold word. When the reading moves past either limit, the block sets a sticky status flag. Battery-insertion and battery-removal events also set sticky flags of their own. A single alert pin reports the latched conditions. The pin is shaped by a 16-bit configuration word, which holds separate enables for the limit alerts, the insertion alert and the removal alert, and a polarity select for the pin.

The host writes both words through one write port, selected by `wr_sel`. A threshold write takes effect on the next clock. A configuration write is held in a staging register and only goes live at the next periodic task boundary. The period is the parameter `TASK_CYCLES`, whose default is a large count that stands for a slow periodic task. Each flag is cleared by its own write-one-to-clear strobe. Violations from comparators outside the block, such as temperature or voltage, arrive as a single level input `ext_viol` and are gated together with the limit alerts.

Top module: `soc_alert_monitor`

## Requirements
- R1: After reset the threshold word reads FF00h and the configuration word reads 0010h. The thermistor-enable bit (bit 4) is the only bit set. All four flags are 0 and `alert_out` is 1, which is the idle level of an active-low pin.
- R2: The upper limit is bits 15:8 of the threshold word and the lower limit is bits 7:0. A threshold write reads back unchanged on the next cycle and is used for comparison from that cycle on.
- R3: `stat_above` is set one clock after a cycle in which `soc_val` is strictly greater than the upper limit. A value equal to the limit does not set it.
- R4: `stat_below` is set one clock after a cycle in which `soc_val` is strictly less than the lower limit. A value equal to the limit does not set it.
- R5: Each flag stays set until its strobe in `clr_stb` is pulsed. The strobes are bit 0 for above, bit 1 for below, bit 2 for insertion and bit 3 for removal. If the condition is still present in the cycle of the clear, setting wins and the flag stays at 1.
- R6: Configuration bit 2 (limit-alert enable) gates only the pin. With it at 0, limit violations still set the flags, but `alert_out` stays idle.
- R7: A pulse on `ins_evt` sets `stat_ins` and a pulse on `rem_evt` sets `stat_rem`, whatever the enables. `stat_ins` drives the pin only when configuration bit 1 is 1, and `stat_rem` only when bit 0 is 1.
- R8: A configuration write changes the live value, and the value read back, only at the next task boundary. Boundaries fall every `TASK_CYCLES` clocks, counted from reset release. Bit 15 always reads 0, even if it was written as 1.
- R9: With configuration bit 11 at 0 the pin is active-low. With bit 11 at 1 the pin is active-high.
- R10: `ext_viol` drives the pin only when configuration bit 2 is 1, and it sets no flag.
- R11: With the reset threshold FF00h, no `soc_val` from 0 to 255 sets either limit flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 for the threshold word, 1 for the configuration word |
| wr_data | input | 16 | Write data |
| clr_stb | input | 4 | Write-one-to-clear strobes: bit 0 above, bit 1 below, bit 2 insertion, bit 3 removal |
| soc_val | input | 8 | Monitored state of charge, in 1% units |
| ins_evt | input | 1 | Battery-insertion event pulse |
| rem_evt | input | 1 | Battery-removal event pulse |
| ext_viol | input | 1 | Combined violation level from external comparators |
| thr_rd | output | 16 | Current threshold word |
| cfg_rd | output | 16 | Live configuration word |
| stat_above | output | 1 | Sticky flag: value above the upper limit |
| stat_below | output | 1 | Sticky flag: value below the lower limit |
| stat_ins | output | 1 | Sticky flag: insertion seen |
| stat_rem | output | 1 | Sticky flag: removal seen |
| alert_out | output | 1 | Alert pin, with programmable polarity |

## Verification
The comparator is driven with values one step below, exactly at and one step above each limit, which separates a strict comparison from an inclusive one. It is also swept over all 256 values under the reset limits, to show that that word can never raise a flag. The alert path is driven with enable and polarity combinations that separate gating the pin from gating the flags, and the event sources from the limit sources. A configuration write is placed just after a task boundary, so that the old value can be observed in the last cycle before the next boundary and the new value in the first cycle after it.

// File: rtl/soc_alert_pkg.sv
package soc_alert_pkg;
  localparam int unsigned REG_W = 16;
  localparam int unsigned SOC_W = REG_W / 2;

  // configuration bit positions used by the alert logic
  localparam int unsigned CFG_EN_REM  = 0;
  localparam int unsigned CFG_EN_INS  = 1;
  localparam int unsigned CFG_EN_LIM  = 2;
  localparam int unsigned CFG_THERM   = 4;
  localparam int unsigned CFG_POL     = 11;
  localparam int unsigned CFG_RSVD    = 15;

  localparam logic [REG_W-1:0] CFG_RESET = REG_W'(1) << CFG_THERM;
  localparam logic [REG_W-1:0] THR_RESET = {{SOC_W{1'b1}}, {SOC_W{1'b0}}};
  localparam logic [REG_W-1:0] RSVD_MASK = REG_W'(1) << CFG_RSVD;

  typedef struct packed {
    logic en_lim;
    logic en_ins;
    logic en_rem;
    logic act_high;
  } alert_ctl_t;

  function automatic logic [SOC_W-1:0] thr_upper(input logic [REG_W-1:0] t);
    return t[REG_W-1:SOC_W];
  endfunction

  function automatic logic [SOC_W-1:0] thr_lower(input logic [REG_W-1:0] t);
    return t[SOC_W-1:0];
  endfunction

  function automatic logic soc_over(input logic [SOC_W-1:0] v, input logic [SOC_W-1:0] lim);
    return v > lim;
  endfunction

  function automatic logic soc_under(input logic [SOC_W-1:0] v, input logic [SOC_W-1:0] lim);
    return v < lim;
  endfunction

  function automatic alert_ctl_t decode_cfg(input logic [REG_W-1:0] c);
    alert_ctl_t r;
    r.en_lim   = c[CFG_EN_LIM];
    r.en_ins   = c[CFG_EN_INS];
    r.en_rem   = c[CFG_EN_REM];
    r.act_high = c[CFG_POL];
    return r;
  endfunction
endpackage

// File: rtl/soc_cfg_reg.sv
module soc_cfg_reg
  import soc_alert_pkg::*;
#(
  parameter int unsigned TASK_CYCLES = 32'd1_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] cfg_q,
  output logic             task_tick
);
  localparam int unsigned CW = (TASK_CYCLES > 2) ? $clog2(TASK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TASK_CYCLES - 1);

  logic [CW-1:0]    cnt;
  logic [REG_W-1:0] pend;
  logic             pend_v;

  assign task_tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      pend   <= CFG_RESET;
      pend_v <= 1'b0;
      cfg_q  <= CFG_RESET;
    end else begin
      cnt <= task_tick ? '0 : cnt + CW'(1);
      if (wr_en) begin
        pend   <= wr_data & ~RSVD_MASK;
        pend_v <= 1'b1;
      end else if (task_tick) begin
        pend_v <= 1'b0;
      end
      if (task_tick && pend_v) cfg_q <= pend;
    end
  end

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !task_tick |=> $stable(cfg_q));
  assert_cfg_apply_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (task_tick && pend_v) |=> (cfg_q == $past(pend)));
  assert_cfg_rsvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    task_tick |=> !cfg_q[CFG_RSVD]);
endmodule

// File: rtl/soc_limit_cmp.sv
module soc_limit_cmp
  import soc_alert_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_wr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [SOC_W-1:0] soc_val,
  input  logic             clr_above,
  input  logic             clr_below,
  output logic [REG_W-1:0] thr_q,
  output logic             over_now,
  output logic             under_now,
  output logic             stat_above,
  output logic             stat_below
);
  assign over_now  = soc_over(soc_val, thr_upper(thr_q));
  assign under_now = soc_under(soc_val, thr_lower(thr_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q      <= THR_RESET;
      stat_above <= 1'b0;
      stat_below <= 1'b0;
    end else begin
      if (thr_wr) thr_q <= wr_data;
      stat_above <= over_now  | (stat_above & ~clr_above);
      stat_below <= under_now | (stat_below & ~clr_below);
    end
  end

  assert_thr_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> (thr_q == $past(wr_data)));
  assert_above_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (soc_val > thr_q[REG_W-1:SOC_W]) |=> stat_above);
  assert_below_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (soc_val < thr_q[SOC_W-1:0]) |=> stat_below);
  assert_above_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_above && !clr_above) |=> stat_above);
  assert_above_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_above && !over_now) |=> !stat_above);
endmodule

// File: rtl/soc_alert_gate.sv
module soc_alert_gate
  import soc_alert_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  alert_ctl_t ctl,
  input  logic       ins_evt,
  input  logic       rem_evt,
  input  logic       clr_ins,
  input  logic       clr_rem,
  input  logic       lim_above,
  input  logic       lim_below,
  input  logic       ext_viol,
  output logic       stat_ins,
  output logic       stat_rem,
  output logic       alert_src,
  output logic       alert_out
);
  logic lim_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_ins <= 1'b0;
      stat_rem <= 1'b0;
    end else begin
      stat_ins <= ins_evt | (stat_ins & ~clr_ins);
      stat_rem <= rem_evt | (stat_rem & ~clr_rem);
    end
  end

  always_comb begin
    lim_any   = lim_above | lim_below | ext_viol;
    alert_src = (ctl.en_lim & lim_any) | (ctl.en_ins & stat_ins) | (ctl.en_rem & stat_rem);
    alert_out = ctl.act_high ? alert_src : ~alert_src;
  end

  assert_pin_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.en_lim || ctl.en_ins || ctl.en_rem) |-> (alert_out != ctl.act_high));
  assert_ins_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ins_evt |=> stat_ins);
  assert_rem_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rem_evt |=> stat_rem);
  assert_pol_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alert_src |-> (alert_out == ctl.act_high));
endmodule

// File: rtl/soc_alert_monitor.sv
module soc_alert_monitor
  import soc_alert_pkg::*;
#(
  parameter int unsigned TASK_CYCLES = 32'd1_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [3:0]       clr_stb,
  input  logic [SOC_W-1:0] soc_val,
  input  logic             ins_evt,
  input  logic             rem_evt,
  input  logic             ext_viol,
  output logic [REG_W-1:0] thr_rd,
  output logic [REG_W-1:0] cfg_rd,
  output logic             stat_above,
  output logic             stat_below,
  output logic             stat_ins,
  output logic             stat_rem,
  output logic             alert_out
);
  logic       thr_wr, cfg_wr, task_tick, over_now, under_now, alert_src;
  alert_ctl_t ctl;

  assign thr_wr = wr_en & ~wr_sel;
  assign cfg_wr = wr_en &  wr_sel;
  assign ctl    = decode_cfg(cfg_rd);

  soc_cfg_reg #(.TASK_CYCLES(TASK_CYCLES)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_data(wr_data),
    .cfg_q(cfg_rd), .task_tick(task_tick)
  );

  soc_limit_cmp u_cmp (
    .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .wr_data(wr_data),
    .soc_val(soc_val), .clr_above(clr_stb[0]), .clr_below(clr_stb[1]),
    .thr_q(thr_rd), .over_now(over_now), .under_now(under_now),
    .stat_above(stat_above), .stat_below(stat_below)
  );

  soc_alert_gate u_gate (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .ins_evt(ins_evt), .rem_evt(rem_evt),
    .clr_ins(clr_stb[2]), .clr_rem(clr_stb[3]),
    .lim_above(stat_above), .lim_below(stat_below), .ext_viol(ext_viol),
    .stat_ins(stat_ins), .stat_rem(stat_rem), .alert_src(alert_src),
    .alert_out(alert_out)
  );

  assert_default_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_rd == THR_RESET) |-> !(over_now || under_now));
  assert_ext_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_viol && ctl.en_lim) |-> alert_src);
endmodule

// File: tb/soc_alert_monitor_bench.sv
module soc_alert_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 0, wr_sel = 0, ins_evt = 0, rem_evt = 0, ext_viol = 0;
  logic [15:0] wr_data = 0;
  logic [3:0]  clr_stb = 0;
  logic [7:0]  soc_val = 8'd50;
  logic [15:0] thr_rd, cfg_rd;
  logic        stat_above, stat_below, stat_ins, stat_rem, alert_out;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  soc_alert_monitor #(.TASK_CYCLES(N)) u_soc_alert_monitor (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .clr_stb(clr_stb), .soc_val(soc_val), .ins_evt(ins_evt), .rem_evt(rem_evt),
    .ext_viol(ext_viol), .thr_rd(thr_rd), .cfg_rd(cfg_rd), .stat_above(stat_above),
    .stat_below(stat_below), .stat_ins(stat_ins), .stat_rem(stat_rem),
    .alert_out(alert_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk or negedge rst_n) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic sel, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic apply_cfg(input logic [15:0] d);
    write_reg(1'b1, d);
    repeat (N + 1) @(negedge clk);
  endtask

  task automatic set_soc(input logic [7:0] v);
    soc_val = v; @(negedge clk);
  endtask

  task automatic clear_all();
    soc_val = 8'd50; clr_stb = 4'hF; @(negedge clk); clr_stb = 0; @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 thr", thr_rd, 16'hFF00);
    check("R1 cfg", cfg_rd, 16'h0010);
    check("R1 flags", {stat_above, stat_below, stat_ins, stat_rem}, 0);
    check("R1 pin", alert_out, 1);
  endtask

  task automatic t_sweep_default();
    logic seen = 0;
    for (int v = 0; v < 256; v++) begin
      set_soc(8'(v));
      if (stat_above || stat_below) seen = 1;
    end
    check("R11 no flag over sweep", seen, 0);
  endtask

  task automatic t_layout();
    write_reg(1'b0, 16'h5A14);
    check("R2 readback", thr_rd, 16'h5A14);
    set_soc(8'h5B); check("R2 upper field", stat_above, 1);
    clear_all();
    set_soc(8'h13); check("R2 lower field", stat_below, 1);
    clear_all();
  endtask

  task automatic t_strict();
    write_reg(1'b0, 16'h5020);
    set_soc(8'h50); check("R3 equal max", stat_above, 0);
    set_soc(8'h51); check("R3 above max", stat_above, 1);
    clear_all();
    set_soc(8'h20); check("R4 equal min", stat_below, 0);
    set_soc(8'h1F); check("R4 below min", stat_below, 1);
    clear_all();
  endtask

  task automatic t_sticky();
    set_soc(8'h60); soc_val = 8'h40; repeat (3) @(negedge clk);
    check("R5 held", stat_above, 1);
    soc_val = 8'h60; clr_stb = 4'h1; @(negedge clk); clr_stb = 0;
    check("R5 set wins", stat_above, 1);
    soc_val = 8'h40; clr_stb = 4'h1; @(negedge clk); clr_stb = 0;
    check("R5 cleared", stat_above, 0);
  endtask

  task automatic t_gate();
    set_soc(8'h10);
    check("R6 flag w/o enable", stat_below, 1);
    check("R6 pin idle", alert_out, 1);
    apply_cfg(16'h0014);
    check("R6 pin active", alert_out, 0);
    clear_all();
    check("R6 pin back idle", alert_out, 1);
  endtask

  task automatic t_ext();
    ext_viol = 1; @(negedge clk);
    check("R10 enabled ext", alert_out, 0);
    check("R10 no flag", {stat_above, stat_below}, 0);
    apply_cfg(16'h0010);
    check("R10 disabled ext", alert_out, 1);
    ext_viol = 0; @(negedge clk);
  endtask

  task automatic t_events();
    ins_evt = 1; @(negedge clk); ins_evt = 0;
    check("R7 ins latched", stat_ins, 1);
    check("R7 ins gated", alert_out, 1);
    rem_evt = 1; @(negedge clk); rem_evt = 0;
    check("R7 rem latched", stat_rem, 1);
    apply_cfg(16'h0011);
    check("R7 rem drives pin", alert_out, 0);
    clr_stb = 4'h8; @(negedge clk); clr_stb = 0;
    check("R7 ins alone masked", alert_out, 1);
    apply_cfg(16'h0012);
    check("R7 ins drives pin", alert_out, 0);
    clear_all();
  endtask

  task automatic t_timing();
    while (cyc % N != 1) @(negedge clk);
    @(negedge clk); wr_en = 1; wr_sel = 1; wr_data = 16'h8814;
    @(negedge clk); wr_en = 0;
    while (cyc % N != N - 1) @(negedge clk);
    check("R8 old before boundary", cfg_rd, 16'h0012);
    @(negedge clk);
    check("R8 new after boundary, bit15 zero", cfg_rd, 16'h0814);
  endtask

  task automatic t_polarity();
    check("R9 active-high idle", alert_out, 0);
    set_soc(8'h00);
    check("R9 active-high asserted", alert_out, 1);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sweep_default();
    t_layout();
    t_strict();
    t_sticky();
    t_gate();
    t_ext();
    t_events();
    t_timing();
    t_polarity();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule